// File: doc/BRIEF.md
# Converter Bring-Up and Poll Sequencer

This block is a small hardware sequencer placed in front of a register-access master that talks to a 24-bit delta-sigma converter. When the start input is accepted, it runs a fixed configuration script through the master. The script has seven single-byte register writes. When the script is done, the block switches to polling. In the polling phase it alternates without end between a read of the 24-bit status register and a read of the first 24-bit conversion-data register.

Each step hands the master one request. The request carries a command byte, a write value and a data length in bytes. The step then waits for the master's done pulse before the next request goes out. The most recent status and data words are held on outputs. A one-cycle valid strobe follows every completed data read.

If the master flags an error, the block stops issuing requests, raises a sticky fault and drops busy. A later accepted start clears the fault and replays the script from its first write.

Top module: `adc_bringup_seq`

## Requirements
- R1: Out of reset, busy, fault, req_valid and data_valid are low, and stat_word and data_word are zero.
- R2: A start pulse is accepted when busy is low. One cycle after acceptance, busy is high and the first request is on the port: req_cmd 0x00, req_wdata 0x000003, req_bytes 1.
- R3: The configuration requests are seven writes with req_bytes 1, in this order as (command, value): (0x00,0x03), (0x00,0x00), (0x08,0x34), (0x0B,0x0A), (0x09,0x02), (0x0E,0x00), (0x01,0x01). A write command has bit 7 clear, bits 6:0 hold the register address, and the value is in req_wdata[7:0] with the upper bits zero.
- R4: req_valid is high for exactly one cycle per request. The next request is raised in the cycle right after the cycle in which done was high, and never earlier.
- R5: Busy falls in the cycle after the done of the seventh write (command 0x01).
- R6: After the script, requests alternate between command 0xB8 (status read) and command 0xB0 (data read), indefinitely. Both have req_bytes 3 and req_wdata 0. A read command has bit 7 set.
- R7: On a successful done of a status read, rdata is stored in stat_word, which is visible in the following cycle.
- R8: On a successful done of a data read, rdata is stored in data_word, and data_valid is high for exactly the following cycle.
- R9: A start pulse while busy is high is ignored, and the script continues without repeating any step.
- R10: A done with err high sets fault and clears busy in the next cycle. No request is issued afterwards. Fault stays set until a start is accepted; that start clears it and restarts the script from the first write.
- R11: A start during the polling phase raises busy in the next cycle. The outstanding read is allowed to finish, and the request after it is the first script write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request to run the script from its first write |
| req_valid | output | 1 | One-cycle request to the register master |
| req_cmd | output | 8 | Command byte: bit 7 is the read flag, bits 6:0 are the register address |
| req_wdata | output | DATA_W | Write value, zero for reads |
| req_bytes | output | LEN_W | Data length of the transfer in bytes |
| done | input | 1 | Master completion pulse |
| err | input | 1 | Master error, qualified by done |
| rdata | input | DATA_W | Read data from the master, qualified by done |
| busy | output | 1 | High from accepted start until the script completes |
| fault | output | 1 | Sticky error indication |
| stat_word | output | DATA_W | Most recent status word |
| data_word | output | DATA_W | Most recent conversion data word |
| data_valid | output | 1 | One-cycle pulse after each data read |

## Verification
Every result in this block appears exactly one cycle after the clock edge that samples its cause. Busy and the first request follow an accepted start by one cycle. Each new request, busy falling, fault rising, the stat_word and data_word updates and the data_valid pulse all follow the sampled done by one cycle. The bench's master model drives done and rdata on falling edges and records the cycle count of each done and each request. Its monitors record the cycle in which busy fell and the cycle in which data_valid rose. The checks then compare these against the done cycle plus one, so there is no timing slack. The master latency is varied, and start pulses are placed in the busy window, in a wait phase of polling and after a fault, to exercise the ignore, restart and fault-clear paths.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int CMD_W       = 8;
  localparam int VAL_W       = 8;
  localparam int CFG_STEPS   = 7;
  localparam int POLL_STEPS  = 2;
  localparam int SCRIPT_LEN  = CFG_STEPS + POLL_STEPS;
  localparam int STEP_W      = $clog2(SCRIPT_LEN);

  localparam logic [STEP_W-1:0] STEP_LAST_CFG = STEP_W'(CFG_STEPS - 1);
  localparam logic [STEP_W-1:0] STEP_STATUS   = STEP_W'(CFG_STEPS);
  localparam logic [STEP_W-1:0] STEP_DATA     = STEP_W'(CFG_STEPS + 1);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_FAULT = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic [CMD_W-1:0] cmd;
    logic [VAL_W-1:0] wval;
    logic             rd;
  } step_t;

  // Script entry for one step index; bit 7 of cmd marks a read.
  function automatic step_t script_step(input logic [STEP_W-1:0] idx);
    step_t s;
    s = '0;
    case (idx)
      STEP_W'(0): s = '{cmd: {1'b0, 7'h00}, wval: 8'h03, rd: 1'b0};
      STEP_W'(1): s = '{cmd: {1'b0, 7'h00}, wval: 8'h00, rd: 1'b0};
      STEP_W'(2): s = '{cmd: {1'b0, 7'h08}, wval: 8'h34, rd: 1'b0};
      STEP_W'(3): s = '{cmd: {1'b0, 7'h0B}, wval: 8'h0A, rd: 1'b0};
      STEP_W'(4): s = '{cmd: {1'b0, 7'h09}, wval: 8'h02, rd: 1'b0};
      STEP_W'(5): s = '{cmd: {1'b0, 7'h0E}, wval: 8'h00, rd: 1'b0};
      STEP_W'(6): s = '{cmd: {1'b0, 7'h01}, wval: 8'h01, rd: 1'b0};
      STEP_W'(7): s = '{cmd: {1'b1, 7'h38}, wval: 8'h00, rd: 1'b1};
      STEP_W'(8): s = '{cmd: {1'b1, 7'h30}, wval: 8'h00, rd: 1'b1};
      default:    s = '0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/adc_seq_rst_sync.sv
module adc_seq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/adc_seq_script.sv
module adc_seq_script
  import adc_seq_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int LEN_W  = 2
) (
  input  logic [STEP_W-1:0] step_i,
  output logic [CMD_W-1:0]  cmd_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [LEN_W-1:0]  bytes_o
);
  localparam int RD_BYTES = DATA_W / 8;

  step_t entry;

  always_comb begin
    entry   = script_step(step_i);
    cmd_o   = entry.cmd;
    wdata_o = {{(DATA_W-VAL_W){1'b0}}, entry.wval};
    bytes_o = entry.rd ? LEN_W'(RD_BYTES) : LEN_W'(1);
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              done_i,
  input  logic              err_i,
  output logic              req_valid_o,
  output logic [STEP_W-1:0] step_o,
  output logic              busy_o,
  output logic              fault_o,
  output logic              cap_stat_o,
  output logic              cap_data_o
);
  seq_state_e        state_q, state_n;
  logic [STEP_W-1:0] step_q, step_n;
  logic              busy_q, busy_n;
  logic              fault_q, fault_n;
  logic              pend_q, pend_n;
  logic              start_ok, ok_done;

  assign start_ok = start_i && !busy_q;
  assign ok_done  = (state_q == ST_WAIT) && done_i && !err_i;

  always_comb begin
    state_n = state_q;
    step_n  = step_q;
    busy_n  = busy_q;
    fault_n = fault_q;
    pend_n  = pend_q;
    case (state_q)
      ST_IDLE, ST_FAULT: begin
        if (start_ok) begin
          state_n = ST_ISSUE;
          step_n  = '0;
          busy_n  = 1'b1;
          fault_n = 1'b0;
        end
      end
      ST_ISSUE: begin
        state_n = ST_WAIT;
        if (start_ok) begin
          busy_n = 1'b1;
          pend_n = 1'b1;
        end
      end
      ST_WAIT: begin
        if (start_ok) begin
          busy_n = 1'b1;
          pend_n = 1'b1;
        end
        if (done_i) begin
          if (err_i) begin
            state_n = ST_FAULT;
            fault_n = 1'b1;
            busy_n  = 1'b0;
            pend_n  = 1'b0;
          end else begin
            state_n = ST_ISSUE;
            if (pend_q || start_ok) begin
              step_n = '0;
              pend_n = 1'b0;
            end else if (step_q == STEP_LAST_CFG) begin
              step_n = step_q + 1'b1;
              busy_n = 1'b0;
            end else if (step_q == STEP_DATA) begin
              step_n = STEP_STATUS;
            end else begin
              step_n = step_q + 1'b1;
            end
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      busy_q  <= 1'b0;
      fault_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      step_q  <= step_n;
      busy_q  <= busy_n;
      fault_q <= fault_n;
      pend_q  <= pend_n;
    end
  end

  assign req_valid_o = (state_q == ST_ISSUE);
  assign step_o      = step_q;
  assign busy_o      = busy_q;
  assign fault_o     = fault_q;
  assign cap_stat_o  = ok_done && (step_q == STEP_STATUS);
  assign cap_data_o  = ok_done && (step_q == STEP_DATA);
endmodule

// File: rtl/adc_seq_capture.sv
module adc_seq_capture #(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_stat_i,
  input  logic              cap_data_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] stat_o,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);
  logic [DATA_W-1:0] stat_q, data_q;
  logic              valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          stat_q <= '0;
    else if (cap_stat_i) stat_q <= rdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          data_q <= '0;
    else if (cap_data_i) data_q <= rdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= cap_data_i;
  end

  assign stat_o  = stat_q;
  assign data_o  = data_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/adc_bringup_seq.sv
module adc_bringup_seq
  import adc_seq_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int LEN_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              req_valid,
  output logic [CMD_W-1:0]  req_cmd,
  output logic [DATA_W-1:0] req_wdata,
  output logic [LEN_W-1:0]  req_bytes,
  input  logic              done,
  input  logic              err,
  input  logic [DATA_W-1:0] rdata,
  output logic              busy,
  output logic              fault,
  output logic [DATA_W-1:0] stat_word,
  output logic [DATA_W-1:0] data_word,
  output logic              data_valid
);
  logic              rst_sync_n;
  logic [STEP_W-1:0] step;
  logic              cap_stat, cap_data;

  adc_seq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  adc_seq_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .start_i     (start),
    .done_i      (done),
    .err_i       (err),
    .req_valid_o (req_valid),
    .step_o      (step),
    .busy_o      (busy),
    .fault_o     (fault),
    .cap_stat_o  (cap_stat),
    .cap_data_o  (cap_data)
  );

  adc_seq_script #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_script (
    .step_i  (step),
    .cmd_o   (req_cmd),
    .wdata_o (req_wdata),
    .bytes_o (req_bytes)
  );

  adc_seq_capture #(.DATA_W(DATA_W)) u_cap (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cap_stat_i (cap_stat),
    .cap_data_i (cap_data),
    .rdata_i    (rdata),
    .stat_o     (stat_word),
    .data_o     (data_word),
    .valid_o    (data_valid)
  );
endmodule

// File: rtl/adc_bringup_seq_chk.sv
module adc_bringup_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       fault,
  input logic       req_valid,
  input logic [7:0] req_cmd,
  input logic       done,
  input logic       err,
  input logic       data_valid
);
  // R4: each request lasts a single cycle
  p_req_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid);

  // R10: a faulted sequencer is quiet and not busy
  p_fault_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!req_valid && !busy));

  // R8: data_valid only follows a clean done of the data read
  p_valid_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> $past(done && !err && req_cmd == 8'hB0));

  // R5: busy ends only after the done of the last configuration write
  p_busy_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !fault) |-> $past(done && req_cmd == 8'h01));

  // R2: an accepted start raises busy
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !(done && err)) |=> busy);

  // R9: a start while busy does not disturb busy
  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && !done) |=> busy);
endmodule

bind adc_bringup_seq adc_bringup_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .start      (start),
  .busy       (busy),
  .fault      (fault),
  .req_valid  (req_valid),
  .req_cmd    (req_cmd),
  .done       (done),
  .err        (err),
  .data_valid (data_valid)
);

// File: tb/adc_bringup_seq_test.sv
module adc_bringup_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          req_valid;
  logic [7:0]    req_cmd;
  logic [DW-1:0] req_wdata;
  logic [1:0]    req_bytes;
  logic          done = 1'b0;
  logic          err = 1'b0;
  logic [DW-1:0] rdata = '0;
  logic          busy, fault, data_valid;
  logic [DW-1:0] stat_word, data_word;

  adc_bringup_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .req_valid(req_valid), .req_cmd(req_cmd), .req_wdata(req_wdata),
    .req_bytes(req_bytes), .done(done), .err(err), .rdata(rdata),
    .busy(busy), .fault(fault), .stat_word(stat_word),
    .data_word(data_word), .data_valid(data_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // master model state and request log
  int lat = 1;
  int err_at = -1;
  int nreq = 0;
  logic [7:0]    lc [64];
  logic [DW-1:0] lw [64];
  logic [1:0]    lb [64];
  int            lcyc [64];
  int            dcyc [64];

  // monitors
  int bfall = -1;
  int vfirst = -1;
  logic [DW-1:0] vdata, vstat;
  int vrun2 = 0;
  logic prev_busy = 1'b0, prev_v = 1'b0;

  task automatic chk(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_cmd(input int i);
    case (i)
      0, 1: return 8'h00;
      2: return 8'h08;
      3: return 8'h0B;
      4: return 8'h09;
      5: return 8'h0E;
      default: return 8'h01;
    endcase
  endfunction

  function automatic logic [7:0] exp_val(input int i);
    case (i)
      0: return 8'h03;
      2: return 8'h34;
      3: return 8'h0A;
      4: return 8'h02;
      6: return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

  // master responder: done 'lat' cycles after the request is seen
  initial begin
    forever begin
      @(negedge clk);
      done = 1'b0;
      err = 1'b0;
      if (req_valid) begin
        int n;
        n = nreq;
        if (n < 64) begin
          lc[n] = req_cmd; lw[n] = req_wdata; lb[n] = req_bytes; lcyc[n] = cyc;
        end
        nreq++;
        repeat (lat) @(negedge clk);
        done = 1'b1;
        err = (n == err_at);
        rdata = (req_cmd == 8'hB8) ? (24'h5A0000 + DW'(n)) : (24'hC30000 + DW'(n));
        if (n < 64) dcyc[n] = cyc;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (prev_busy && !busy) bfall = cyc;
      prev_busy = busy;
      if (data_valid) begin
        if (vfirst < 0) begin
          vfirst = cyc; vdata = data_word; vstat = stat_word;
        end
        if (prev_v) vrun2 = 1;
      end
      prev_v = data_valid;
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    start = 1'b0;
    err_at = -1;
    repeat (6) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    nreq = 0; bfall = -1; vfirst = -1; vrun2 = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic check_script(input string rq, input int base);
    for (int i = 0; i < 7; i++) begin
      chk(rq, $sformatf("cmd of write %0d", i), 32'(lc[base+i]), 32'(exp_cmd(i)));
      chk(rq, $sformatf("value of write %0d", i), 32'(lw[base+i]), 32'(exp_val(i)));
      chk(rq, $sformatf("bytes of write %0d", i), 32'(lb[base+i]), 32'd1);
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "busy", 32'(busy), 0);
    chk("R1", "fault", 32'(fault), 0);
    chk("R1", "req_valid", 32'(req_valid), 0);
    chk("R1", "data_valid", 32'(data_valid), 0);
    chk("R1", "stat_word", 32'(stat_word), 0);
    chk("R1", "data_word", 32'(data_word), 0);
  endtask

  task automatic t_bringup(input int l);
    do_reset();
    lat = l;
    pulse_start();
    chk("R2", "busy after start", 32'(busy), 1);
    chk("R2", "first req_valid", 32'(req_valid), 1);
    chk("R2", "first cmd", 32'(req_cmd), 32'h00);
    chk("R2", "first value", 32'(req_wdata), 32'h03);
    wait (nreq >= 11);
    repeat (2) @(negedge clk);
    check_script("R3", 0);
    for (int i = 7; i < 11; i++) begin
      chk("R6", $sformatf("poll cmd %0d", i), 32'(lc[i]), (i % 2 == 1) ? 32'hB8 : 32'hB0);
      chk("R6", $sformatf("poll bytes %0d", i), 32'(lb[i]), 32'd3);
      chk("R6", $sformatf("poll wdata %0d", i), 32'(lw[i]), 32'd0);
    end
    for (int i = 1; i < 11; i++)
      chk("R4", $sformatf("request %0d cycle", i), 32'(lcyc[i]), 32'(dcyc[i-1] + 1));
    chk("R5", "busy fall cycle", 32'(bfall), 32'(dcyc[6] + 1));
    chk("R8", "valid cycle", 32'(vfirst), 32'(dcyc[8] + 1));
    chk("R8", "data word", 32'(vdata), 32'h C30008);
    chk("R8", "valid width", 32'(vrun2), 0);
    chk("R7", "status word", 32'(vstat), 32'h5A0007);
  endtask

  task automatic t_busy_start();
    do_reset();
    lat = 2;
    pulse_start();
    wait (nreq >= 3);
    pulse_start();
    chk("R9", "busy after ignored start", 32'(busy), 1);
    wait (nreq >= 9);
    check_script("R9", 0);
    chk("R9", "first poll after script", 32'(lc[7]), 32'hB8);
  endtask

  task automatic t_fault();
    int k;
    do_reset();
    lat = 1;
    err_at = 3;
    pulse_start();
    wait (nreq >= 4);
    repeat (20) @(negedge clk);
    chk("R10", "fault set", 32'(fault), 1);
    chk("R10", "busy cleared", 32'(busy), 0);
    chk("R10", "no further requests", 32'(nreq), 4);
    chk("R10", "data_word untouched", 32'(data_word), 0);
    err_at = -1;
    k = nreq;
    pulse_start();
    chk("R10", "fault cleared by start", 32'(fault), 0);
    chk("R10", "busy after restart", 32'(busy), 1);
    wait (nreq >= k + 7);
    check_script("R10", k);
  endtask

  task automatic t_restart();
    int k;
    do_reset();
    lat = 2;
    pulse_start();
    wait (nreq == 10);
    k = nreq;
    pulse_start();
    chk("R11", "busy after poll start", 32'(busy), 1);
    wait (nreq >= k + 8);
    check_script("R11", k);
    chk("R11", "poll resumes", 32'(lc[k+7]), 32'hB8);
    chk("R11", "restart follows done", 32'(lcyc[k]), 32'(dcyc[k-1] + 1));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_bringup(1);
    t_bringup(3);
    t_busy_start();
    t_fault();
    t_restart();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule